// File: doc/BRIEF.md
# Buffer Pause Hysteresis Controller

This block watches how many blocks of a shared, block-organised receive buffer are in use and tells each write client (one per receive port) when to back off. It counts one block up on every allocate strobe and one down on every release strobe. The free-block count is the buffer size minus the used count. Each client has two 10-bit levels. Pause turns on when free space falls to the lower level, and it turns off only when free space climbs back to the upper level. The gap between the two levels stops pause from toggling on every block. A separate write-full line per client is high while no block is free.

For each client, the block counts the cycles in which pause was high and the cycles in which write-full was high. The counters saturate, and reading one returns its value and clears it. A small word-addressed register port sets the levels and reads the counters and the used-block count. A software reset returns the whole block to its power-up state. The block drives no buffer memory and no list storage: it sees only the two strobes.

Top module: `bufpause_ctrl`

## Requirements
- R1: After reset the used-block count is 0, every pause and write-full output is low, every statistics counter reads 0, and each client's assert level reads DEF_ON and its release level reads DEF_OFF.
- R2: An allocate strobe alone raises the used count by one, and a release strobe alone lowers it by one. Both strobes together leave it unchanged. An allocate while all blocks are used is ignored, and so is a release while none are used. The used count reads at register address 1.
- R3: A client's pause output goes high on the clock edge after a cycle in which it was low and the free count was at or below that client's assert level.
- R4: Once high, a client's pause stays high while the free count is below that client's release level. It goes low on the edge after a cycle in which the free count was at or above the release level. Once low, it stays low while the free count is above the assert level.
- R5: Each client has its own levels. Client c's assert level is at address 8+2c and its release level at address 9+2c. Writes set bits [9:0] and reads return them zero-extended, so one client's levels do not affect another client's pause.
- R6: Every write-full output is high in exactly the cycles in which the used count equals TOTAL_BLOCKS. It falls in the same cycle that a release leaves one block free.
- R7: Client c's pause counter, read at address 32+c, grows by one for every clock edge at which that client's pause output was high.
- R8: Client c's write-full counter, read at address 40+c, grows by one for every clock edge at which write-full was high.
- R9: Reading a statistics counter (reg_rd_i high with its address) returns the value during that cycle and clears the counter at the edge. If the counter would also have counted at that edge, it restarts at 1 instead of 0.
- R10: A statistics counter stops at all-ones (2^STAT_W-1) and does not wrap.
- R11: A write to address 0 with bit 0 set returns all state, including the levels, to the R1 values at that edge. A write to address 0 with bit 0 clear has no effect.
- R12: Read data is combinational. While reg_rd_i is high it shows the addressed value in the same cycle, and it is 0 when reg_rd_i is low or the address is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| alloc_i | input | 1 | One buffer block taken this cycle |
| release_i | input | 1 | One buffer block returned this cycle |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears statistics counters) |
| reg_addr_i | input | 6 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid in the strobe cycle |
| pause_o | output | NUM_CLIENTS | Per-client pause request |
| wfull_o | output | NUM_CLIENTS | Per-client write-full indication |

## Verification
A wrong used count shows up at the ports within a cycle. An occupancy register that drifts makes pause rise or fall one edge early or late against the strobe history, and it moves the write-full edge. The hysteresis is checked from both sides: the free count is walked through the band between the two levels while rising and while falling, so a single-level comparator flips pause where it should hold. A counter that loses its restart-at-one or its saturation is caught on the next read, because the bench reads counters back to back and after held intervals of known length.

// File: rtl/bufpause_pkg.sv
`timescale 1ns/1ps
package bufpause_pkg;

    localparam int unsigned THR_W       = 10;
    localparam int unsigned OCC_W       = 24;
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned ADDR_W      = 6;
    localparam int unsigned MAX_CLIENTS = 8;
    localparam int unsigned CLI_W       = $clog2(MAX_CLIENTS);

    localparam int unsigned ADDR_SWRST     = 0;
    localparam int unsigned ADDR_OCC       = 1;
    localparam int unsigned ADDR_THR_BASE  = 8;
    localparam int unsigned ADDR_PCNT_BASE = 32;
    localparam int unsigned ADDR_FCNT_BASE = 40;

    typedef struct packed {
        logic [THR_W-1:0] on_lvl;
        logic [THR_W-1:0] off_lvl;
    } thr_pair_t;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_SWRST,
        RK_OCC,
        RK_THR_ON,
        RK_THR_OFF,
        RK_PCNT,
        RK_FCNT
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e        kind;
        logic [CLI_W-1:0] cli;
    } reg_dec_t;

    function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a,
                                             input int unsigned n_cli);
        int unsigned ai;
        reg_dec_t    d;
        ai     = int'(a);
        d.kind = RK_NONE;
        d.cli  = '0;
        if (ai == ADDR_SWRST) begin
            d.kind = RK_SWRST;
        end else if (ai == ADDR_OCC) begin
            d.kind = RK_OCC;
        end else if (ai >= ADDR_THR_BASE && ai < ADDR_THR_BASE + 2 * n_cli) begin
            d.kind = a[0] ? RK_THR_OFF : RK_THR_ON;
            d.cli  = CLI_W'((ai - ADDR_THR_BASE) / 2);
        end else if (ai >= ADDR_PCNT_BASE && ai < ADDR_PCNT_BASE + n_cli) begin
            d.kind = RK_PCNT;
            d.cli  = CLI_W'(ai - ADDR_PCNT_BASE);
        end else if (ai >= ADDR_FCNT_BASE && ai < ADDR_FCNT_BASE + n_cli) begin
            d.kind = RK_FCNT;
            d.cli  = CLI_W'(ai - ADDR_FCNT_BASE);
        end
        return d;
    endfunction

endpackage

// File: rtl/bufpause_occ.sv
`timescale 1ns/1ps
module bufpause_occ
    import bufpause_pkg::*;
#(
    parameter int unsigned TOTAL_BLOCKS = 640
) (
    input  logic             clk_i,
    input  logic             clr_i,
    input  logic             alloc_i,
    input  logic             release_i,
    output logic [OCC_W-1:0] occ_o,
    output logic [OCC_W-1:0] free_o,
    output logic             full_o
);
    localparam logic [OCC_W-1:0] TOTAL_V = OCC_W'(TOTAL_BLOCKS);

    logic [OCC_W-1:0] occ_q;
    logic             take;
    logic             give;

    always_comb begin
        take = alloc_i && !release_i && (occ_q != TOTAL_V);
        give = release_i && !alloc_i && (occ_q != '0);
    end

    always_ff @(posedge clk_i) begin
        if (clr_i) begin
            occ_q <= '0;
        end else if (take) begin
            occ_q <= occ_q + OCC_W'(1);
        end else if (give) begin
            occ_q <= occ_q - OCC_W'(1);
        end
    end

    assign occ_o  = occ_q;
    assign free_o = TOTAL_V - occ_q;
    assign full_o = (occ_q == TOTAL_V);
endmodule

// File: rtl/bufpause_hyst.sv
`timescale 1ns/1ps
module bufpause_hyst
    import bufpause_pkg::*;
(
    input  logic             clk_i,
    input  logic             clr_i,
    input  logic [OCC_W-1:0] free_i,
    input  thr_pair_t        thr_i,
    output logic             pause_o
);
    logic pause_q;
    logic hit_on;
    logic hit_off;

    always_comb begin
        hit_on  = (free_i <= OCC_W'(thr_i.on_lvl));
        hit_off = (free_i >= OCC_W'(thr_i.off_lvl));
    end

    always_ff @(posedge clk_i) begin
        if (clr_i) begin
            pause_q <= 1'b0;
        end else if (!pause_q && hit_on) begin
            pause_q <= 1'b1;
        end else if (pause_q && hit_off) begin
            pause_q <= 1'b0;
        end
    end

    assign pause_o = pause_q;
endmodule

// File: rtl/bufpause_stat.sv
`timescale 1ns/1ps
module bufpause_stat #(
    parameter int unsigned STAT_W = 32
) (
    input  logic              clk_i,
    input  logic              clr_i,
    input  logic              inc_i,
    input  logic              rd_clr_i,
    output logic [STAT_W-1:0] cnt_o
);
    logic [STAT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (clr_i) begin
            cnt_q <= '0;
        end else if (rd_clr_i) begin
            cnt_q <= inc_i ? STAT_W'(1) : '0;
        end else if (inc_i && (cnt_q != '1)) begin
            cnt_q <= cnt_q + STAT_W'(1);
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/bufpause_regs.sv
`timescale 1ns/1ps
module bufpause_regs
    import bufpause_pkg::*;
#(
    parameter int unsigned NUM_CLIENTS = 2,
    parameter int unsigned STAT_W      = 32,
    parameter int unsigned DEF_ON      = 64,
    parameter int unsigned DEF_OFF     = 128
) (
    input  logic                                clk_i,
    input  logic                                rst_i,
    input  logic                                clr_i,
    input  logic                                wr_i,
    input  logic                                rd_i,
    input  logic [ADDR_W-1:0]                   addr_i,
    input  logic [DATA_W-1:0]                   wdata_i,
    output logic [DATA_W-1:0]                   rdata_o,
    output logic                                sw_rst_o,
    input  logic [OCC_W-1:0]                    occ_i,
    input  logic [NUM_CLIENTS-1:0][STAT_W-1:0]  pcnt_i,
    input  logic [NUM_CLIENTS-1:0][STAT_W-1:0]  fcnt_i,
    output logic [NUM_CLIENTS-1:0]              pclr_o,
    output logic [NUM_CLIENTS-1:0]              fclr_o,
    output thr_pair_t [NUM_CLIENTS-1:0]         thr_o
);
    reg_dec_t dec;
    logic     unused_wdata;

    assign dec          = decode_addr(addr_i, NUM_CLIENTS);
    assign unused_wdata = ^wdata_i[DATA_W-1:THR_W] ^ rst_i;
    assign sw_rst_o     = wr_i && (dec.kind == RK_SWRST) && wdata_i[0];

    for (genvar c = 0; c < NUM_CLIENTS; c++) begin : g_thr
        logic sel;
        assign sel = (dec.cli == CLI_W'(c));

        always_ff @(posedge clk_i) begin
            if (clr_i) begin
                thr_o[c].on_lvl  <= THR_W'(DEF_ON);
                thr_o[c].off_lvl <= THR_W'(DEF_OFF);
            end else if (wr_i && sel) begin
                if (dec.kind == RK_THR_ON) begin
                    thr_o[c].on_lvl <= wdata_i[THR_W-1:0];
                end
                if (dec.kind == RK_THR_OFF) begin
                    thr_o[c].off_lvl <= wdata_i[THR_W-1:0];
                end
            end
        end

        assign pclr_o[c] = rd_i && sel && (dec.kind == RK_PCNT);
        assign fclr_o[c] = rd_i && sel && (dec.kind == RK_FCNT);
    end

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            case (dec.kind)
                RK_OCC: rdata_o = DATA_W'(occ_i);
                RK_THR_ON, RK_THR_OFF, RK_PCNT, RK_FCNT: begin
                    for (int c = 0; c < NUM_CLIENTS; c++) begin
                        if (dec.cli == CLI_W'(c)) begin
                            case (dec.kind)
                                RK_THR_ON:  rdata_o = DATA_W'(thr_o[c].on_lvl);
                                RK_THR_OFF: rdata_o = DATA_W'(thr_o[c].off_lvl);
                                RK_PCNT:    rdata_o = DATA_W'(pcnt_i[c]);
                                default:    rdata_o = DATA_W'(fcnt_i[c]);
                            endcase
                        end
                    end
                end
                default: rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/bufpause_ctrl.sv
`timescale 1ns/1ps
module bufpause_ctrl
    import bufpause_pkg::*;
#(
    parameter int unsigned NUM_CLIENTS  = 2,
    parameter int unsigned TOTAL_BLOCKS = 640,
    parameter int unsigned STAT_W       = 32,
    parameter int unsigned DEF_ON       = 64,
    parameter int unsigned DEF_OFF      = 128
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   alloc_i,
    input  logic                   release_i,
    input  logic                   reg_wr_i,
    input  logic                   reg_rd_i,
    input  logic [5:0]             reg_addr_i,
    input  logic [31:0]            reg_wdata_i,
    output logic [31:0]            reg_rdata_o,
    output logic [NUM_CLIENTS-1:0] pause_o,
    output logic [NUM_CLIENTS-1:0] wfull_o
);
    logic                               sw_rst;
    logic                               clr;
    logic [OCC_W-1:0]                   occ_q;
    logic [OCC_W-1:0]                   free_blks;
    logic                               occ_full;
    thr_pair_t [NUM_CLIENTS-1:0]        thr_q;
    logic [NUM_CLIENTS-1:0][STAT_W-1:0] pcnt;
    logic [NUM_CLIENTS-1:0][STAT_W-1:0] fcnt;
    logic [NUM_CLIENTS-1:0]             pclr;
    logic [NUM_CLIENTS-1:0]             fclr;

    assign clr = rst_i | sw_rst;

    bufpause_occ #(.TOTAL_BLOCKS(TOTAL_BLOCKS)) u_occ (
        .clk_i     (clk_i),
        .clr_i     (clr),
        .alloc_i   (alloc_i),
        .release_i (release_i),
        .occ_o     (occ_q),
        .free_o    (free_blks),
        .full_o    (occ_full)
    );

    bufpause_regs #(
        .NUM_CLIENTS (NUM_CLIENTS),
        .STAT_W      (STAT_W),
        .DEF_ON      (DEF_ON),
        .DEF_OFF     (DEF_OFF)
    ) u_regs (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .clr_i    (clr),
        .wr_i     (reg_wr_i),
        .rd_i     (reg_rd_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .rdata_o  (reg_rdata_o),
        .sw_rst_o (sw_rst),
        .occ_i    (occ_q),
        .pcnt_i   (pcnt),
        .fcnt_i   (fcnt),
        .pclr_o   (pclr),
        .fclr_o   (fclr),
        .thr_o    (thr_q)
    );

    for (genvar c = 0; c < NUM_CLIENTS; c++) begin : g_cli
        assign wfull_o[c] = occ_full;

        bufpause_hyst u_hyst (
            .clk_i   (clk_i),
            .clr_i   (clr),
            .free_i  (free_blks),
            .thr_i   (thr_q[c]),
            .pause_o (pause_o[c])
        );

        bufpause_stat #(.STAT_W(STAT_W)) u_pstat (
            .clk_i    (clk_i),
            .clr_i    (clr),
            .inc_i    (pause_o[c]),
            .rd_clr_i (pclr[c]),
            .cnt_o    (pcnt[c])
        );

        bufpause_stat #(.STAT_W(STAT_W)) u_fstat (
            .clk_i    (clk_i),
            .clr_i    (clr),
            .inc_i    (wfull_o[c]),
            .rd_clr_i (fclr[c]),
            .cnt_o    (fcnt[c])
        );
    end
endmodule

// File: rtl/bufpause_chk.sv
`timescale 1ns/1ps
module bufpause_chk
    import bufpause_pkg::*;
#(
    parameter int unsigned TOTAL_BLOCKS = 640,
    parameter int unsigned STAT_W       = 32
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              sw_rst,
    input logic              alloc_i,
    input logic              release_i,
    input logic [OCC_W-1:0]  occ,
    input logic [OCC_W-1:0]  free_blks,
    input logic [THR_W-1:0]  on0,
    input logic [THR_W-1:0]  off0,
    input logic              pause0,
    input logic              wfull0,
    input logic              pclr0,
    input logic [STAT_W-1:0] pcnt0
);
    localparam logic [OCC_W-1:0] TOTAL_V = OCC_W'(TOTAL_BLOCKS);

    // R2
    occ_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        occ <= TOTAL_V);

    // R2
    occ_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (alloc_i && !release_i && occ < TOTAL_V && !sw_rst)
        |=> occ == $past(occ) + OCC_W'(1));

    // R3
    pause_on_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!pause0 && free_blks <= OCC_W'(on0) && !sw_rst) |=> pause0);

    // R4
    pause_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (pause0 && free_blks < OCC_W'(off0) && !sw_rst) |=> pause0);

    // R6
    wfull_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wfull0 && alloc_i && !release_i && !sw_rst) |=> wfull0);

    // R9
    cor_restart_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (pclr0 && pause0 && !sw_rst) |=> pcnt0 == STAT_W'(1));

    // R11
    swrst_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        sw_rst |=> (occ == '0) && !pause0 && (pcnt0 == '0));
endmodule

bind bufpause_ctrl bufpause_chk #(
    .TOTAL_BLOCKS (TOTAL_BLOCKS),
    .STAT_W       (STAT_W)
) chk_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .sw_rst    (sw_rst),
    .alloc_i   (alloc_i),
    .release_i (release_i),
    .occ       (occ_q),
    .free_blks (free_blks),
    .on0       (thr_q[0].on_lvl),
    .off0      (thr_q[0].off_lvl),
    .pause0    (pause_o[0]),
    .wfull0    (wfull_o[0]),
    .pclr0     (pclr[0]),
    .pcnt0     (pcnt[0])
);

// File: tb/bufpause_ctrl_tb_top.sv
`timescale 1ns/1ps
module bufpause_ctrl_tb_top;
    localparam int TOTAL = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        alloc = 1'b0;
    logic        rel = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  pause;
    logic [1:0]  wfull;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    bufpause_ctrl #(
        .NUM_CLIENTS  (2),
        .TOTAL_BLOCKS (TOTAL),
        .STAT_W       (8),
        .DEF_ON       (8),
        .DEF_OFF      (12)
    ) dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .alloc_i     (alloc),
        .release_i   (rel),
        .reg_wr_i    (reg_wr),
        .reg_rd_i    (reg_rd),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .pause_o     (pause),
        .wfull_o     (wfull)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic alloc_n(input int n);
        repeat (n) begin
            alloc = 1'b1;
            @(negedge clk);
        end
        alloc = 1'b0;
    endtask

    task automatic release_n(input int n);
        repeat (n) begin
            rel = 1'b1;
            @(negedge clk);
        end
        rel = 1'b0;
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [5:0] a, output logic [31:0] v);
        reg_rd = 1'b1; reg_addr = a;
        #5;
        v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 pause", {30'd0, pause}, 32'd0);
        check("R1 wfull", {30'd0, wfull}, 32'd0);
        check("R12 idle rdata", reg_rdata, 32'd0);
        rd_reg(6'd1, v);  check("R1 occupancy", v, 32'd0);
        rd_reg(6'd8, v);  check("R1 R12 on level c0", v, 32'd8);
        rd_reg(6'd9, v);  check("R1 R12 off level c0", v, 32'd12);
        rd_reg(6'd11, v); check("R1 R12 off level c1", v, 32'd12);
        rd_reg(6'd33, v); check("R1 pause count c1", v, 32'd0);
        rd_reg(6'd41, v); check("R1 full count c1", v, 32'd0);
        rd_reg(6'd20, v); check("R12 unmapped", v, 32'd0);
    endtask

    task automatic t_occupancy;
        logic [31:0] v;
        wr_reg(6'd0, 32'd1);
        alloc_n(5);
        release_n(2);
        alloc = 1'b1; rel = 1'b1;
        @(negedge clk);
        alloc = 1'b0; rel = 1'b0;
        rd_reg(6'd1, v); check("R2 count after mix", v, 32'd3);
        release_n(3);
        release_n(1);
        rd_reg(6'd1, v); check("R2 release at empty", v, 32'd0);
    endtask

    task automatic t_hysteresis;
        logic [31:0] v;
        wr_reg(6'd0, 32'd1);
        wr_reg(6'd10, 32'd4);
        wr_reg(6'd11, 32'd10);
        rd_reg(6'd10, v); check("R5 on level c1", v, 32'd4);
        alloc_n(32);
        check("R3 one-cycle lag", {30'd0, pause}, 32'd0);
        step(1);
        check("R3 R5 c0 asserts", {30'd0, pause}, 32'd1);
        alloc_n(4);
        check("R5 c1 not yet", {30'd0, pause}, 32'd1);
        step(1);
        check("R3 c1 asserts", {30'd0, pause}, 32'd3);
        release_n(6);
        check("R4 both held", {30'd0, pause}, 32'd3);
        release_n(1);
        check("R4 R5 c1 released c0 held", {30'd0, pause}, 32'd1);
        release_n(1);
        check("R4 c0 lag", {30'd0, pause}, 32'd1);
        step(1);
        check("R4 c0 released", {30'd0, pause}, 32'd0);
        alloc_n(3);
        step(1);
        check("R4 stays low in band", {30'd0, pause}, 32'd0);
        alloc_n(1);
        step(1);
        check("R3 reassert", {30'd0, pause}, 32'd1);
    endtask

    task automatic t_stats;
        logic [31:0] v;
        wr_reg(6'd0, 32'd1);
        alloc_n(32);
        step(1);
        rd_reg(6'd32, v);
        rd_reg(6'd32, v); check("R9 restart at one", v, 32'd1);
        step(4);
        rd_reg(6'd32, v); check("R7 pause cycles", v, 32'd5);
        step(300);
        rd_reg(6'd32, v); check("R10 saturate", v, 32'd255);
        rd_reg(6'd40, v); check("R8 no full cycles", v, 32'd0);
    endtask

    task automatic t_wfull;
        logic [31:0] v;
        wr_reg(6'd0, 32'd1);
        alloc_n(TOTAL - 1);
        check("R6 not full", {30'd0, wfull}, 32'd0);
        alloc_n(1);
        check("R6 full same cycle", {30'd0, wfull}, 32'd3);
        alloc_n(1);
        rd_reg(6'd1, v); check("R2 alloc at full", v, TOTAL);
        rd_reg(6'd40, v);
        rd_reg(6'd40, v); check("R9 full restart", v, 32'd1);
        step(5);
        rd_reg(6'd40, v); check("R8 full cycles", v, 32'd6);
        release_n(1);
        check("R6 full drops", {30'd0, wfull}, 32'd0);
        rd_reg(6'd40, v); check("R8 release edge counted", v, 32'd2);
        rd_reg(6'd40, v); check("R9 cleared", v, 32'd0);
    endtask

    task automatic t_soft_reset;
        logic [31:0] v;
        wr_reg(6'd0, 32'd1);
        wr_reg(6'd10, 32'd20);
        alloc_n(10);
        wr_reg(6'd0, 32'd0);
        rd_reg(6'd1, v);  check("R11 zero write keeps count", v, 32'd10);
        rd_reg(6'd10, v); check("R11 zero write keeps level", v, 32'd20);
        alloc_n(25);
        step(1);
        check("R11 pre pause", {30'd0, pause}, 32'd3);
        wr_reg(6'd0, 32'd1);
        check("R11 pause cleared", {30'd0, pause}, 32'd0);
        rd_reg(6'd1, v);  check("R11 count cleared", v, 32'd0);
        rd_reg(6'd10, v); check("R11 level default", v, 32'd8);
        rd_reg(6'd33, v); check("R11 stats cleared", v, 32'd0);
    endtask

    initial begin
        #(20 * 200000);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_occupancy();
        t_hysteresis();
        t_stats();
        t_wfull();
        t_soft_reset();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule